// File: doc/BRIEF.md
# Peak-Current PWM Cycle Controller

This block makes the per-cycle gate decision of a peak-current-mode switching controller. An oscillator pulse starts each on-time. The gate then stays on until one of three things happens: the PWM comparator trips, the over-current comparator trips, or the on-time reaches three quarters of the switching period. Both comparator trips are masked for a short blanking interval after turn-on, so that the turn-on spike cannot end the pulse early. The period is measured from the spacing of the oscillator pulses, so the duty limit and the slope-compensation point follow a frequency that varies.

After reset, a time-based soft-start raises the peak-limit reference code in four equal-duration steps from the low level to the full level. The block also samples a "sensed current too low" flag once in every on-time. Three low samples in a row indicate an open or shorted sense path. When that happens the block latches an auto-restart fault that holds the gate off until an external restart pulse arrives. The restart also starts the soft-start again.

Top module: `pcm_cycle_ctrl`

## Requirements
- R1: The gate rises on the first clock edge that samples `period_start_i` high while the gate is off and no fault is latched. That edge is counted as on-time cycle 1, and each further gate-high cycle adds one to the count.
- R2: When `pwm_trip_i` is high during on-time cycle k with k > LEB_CYC, the gate falls at the end of that cycle, so the pulse is k cycles wide.
- R3: `ocp_trip_i` ends the on-time in the same way as the PWM trip, with the same blanking.
- R4: Both trips are ignored during on-time cycles 1..LEB_CYC. A trip that is held from turn-on gives a pulse of LEB_CYC+1 cycles (11 with the bench settings).
- R5: The gate falls at the end of on-time cycle k once 4·k ≥ 3·P. P is the interval in clock cycles between the two most recent period-start pulses, or DEF_PERIOD until two pulses have been seen. With P=100 the widest pulse is 75 cycles; with P=60 it is 45.
- R6: `slope_en_o` is high exactly while the gate is high and 5·k > 2·P, where k is the on-time cycle. Its first high cycle is 41 for P=100 and 25 for P=60.
- R7: `ref_code_o` equals REF_START + s·(REF_END−REF_START)/(SS_STEPS−1), using integer division. The step s starts at 0 and rises by one every SS_STEP_CYC cycles after reset or restart, then holds at SS_STEPS−1. With the defaults the codes are 30, 46, 63 and 80, and the code never falls except through restart.
- R8: `cs_low_i` is sampled in on-time cycle SAMPLE_CYC. On the third consecutive low sample, `fault_o` rises and the gate falls at the end of that cycle, giving a pulse of SAMPLE_CYC cycles.
- R9: A sample that finds `cs_low_i` low clears the consecutive-low count to zero. A pulse that ends before cycle SAMPLE_CYC leaves the count unchanged.
- R10: While `fault_o` is high, the gate stays low and period-start pulses are ignored.
- R11: `restart_i` clears the fault and the low count, forces the gate low, and restarts the soft-start at REF_START. The next period start then produces a normal pulse.
- R12: During reset the gate, fault and slope outputs are low and `ref_code_o` equals REF_START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | One-cycle oscillator pulse that opens a switching period |
| pwm_trip_i | input | 1 | PWM comparator: sensed ramp is above feedback |
| ocp_trip_i | input | 1 | Over-current comparator: sense is above the peak limit |
| cs_low_i | input | 1 | Sensed current is below the low threshold |
| restart_i | input | 1 | Clears an auto-restart fault and restarts soft-start |
| gate_o | output | 1 | Gate-on request |
| slope_en_o | output | 1 | Slope compensation enable |
| ref_code_o | output | REF_W | Peak-limit reference code |
| fault_o | output | 1 | Auto-restart fault latched |

## Verification
A wrong on-time count or period register changes the pulse width or the first slope-enable cycle in the very next pulse. The bench therefore measures both figures for every pulse against the width and threshold formulas. A consecutive-low counter that fails to clear, or that moves on a pulse too short to be sampled, does not show until one or two pulses later, when `fault_o` rises where it should not. For that reason the stimulus interleaves low, short and normal pulses. A soft-start timer error is visible on `ref_code_o` within one step interval, and the code is sampled in the middle of each step so that an off-by-one edge cannot hide a wrong level.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // Reference level of soft-start step s; integer division as the requirement states.
  function automatic int unsigned ss_level(int unsigned s, int unsigned steps,
                                           int unsigned lo, int unsigned hi);
    return lo + (s * (hi - lo)) / (steps - 1);
  endfunction
endpackage

// File: rtl/pcm_period_meas.sv
module pcm_period_meas #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned DEF_PERIOD = 1250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] DEF_P   = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0] cnt_q, last_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= DEF_P;
      seen_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(1);
      seen_q <= 1'b1;
      if (seen_q) last_q <= cnt_q;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign period_o = last_q;
endmodule

// File: rtl/pcm_soft_start.sv
module pcm_soft_start #(
  parameter int unsigned SS_STEPS    = 4,
  parameter int unsigned SS_STEP_CYC = 375000,
  parameter int unsigned REF_W       = 8,
  parameter int unsigned REF_START   = 30,
  parameter int unsigned REF_END     = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [REF_W-1:0] ref_o
);
  localparam int unsigned STEP_W = (SS_STEPS > 2) ? $clog2(SS_STEPS) : 1;
  localparam int unsigned TMR_W  = (SS_STEP_CYC > 2) ? $clog2(SS_STEP_CYC) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SS_STEPS - 1);
  localparam logic [TMR_W-1:0]  TMR_END   = TMR_W'(SS_STEP_CYC - 1);

  logic [STEP_W-1:0] step_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [REF_W-1:0]  lvl [SS_STEPS];

  for (genvar k = 0; k < SS_STEPS; k++) begin : g_lvl
    assign lvl[k] = REF_W'(pcm_pkg::ss_level(k, SS_STEPS, REF_START, REF_END));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      tmr_q  <= '0;
    end else if (restart_i) begin
      step_q <= '0;
      tmr_q  <= '0;
    end else if (step_q != LAST_STEP) begin
      if (tmr_q == TMR_END) begin
        tmr_q  <= '0;
        step_q <= step_q + 1'b1;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign ref_o = lvl[step_q];
endmodule

// File: rtl/pcm_gate_ctrl.sv
module pcm_gate_ctrl #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned LEB_CYC    = 40,
  parameter int unsigned SAMPLE_CYC = 50,
  parameter int unsigned LOW_LIMIT  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             period_start_i,
  input  logic             pwm_trip_i,
  input  logic             ocp_trip_i,
  input  logic             cs_low_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             gate_o,
  output logic             slope_en_o,
  output logic             fault_o
);
  localparam int unsigned MUL_W = CNT_W + 3;
  localparam int unsigned LOW_W = $clog2(LOW_LIMIT + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(LOW_LIMIT - 1);

  logic             gate_q, fault_q;
  logic [CNT_W-1:0] on_q;
  logic [LOW_W-1:0] low_q;

  logic [MUL_W-1:0] on_x4, on_x5, per_x2, per_x3;
  logic blank_done, trip_cut, max_cut, sample_hit, low_last;

  // Duty thresholds as constant multiplies; no divider on the period.
  always_comb begin
    on_x4  = MUL_W'(on_q) << 2;
    on_x5  = on_x4 + MUL_W'(on_q);
    per_x2 = MUL_W'(period_i) << 1;
    per_x3 = per_x2 + MUL_W'(period_i);
  end

  assign blank_done = on_q > CNT_W'(LEB_CYC);
  assign trip_cut   = gate_q && blank_done && (pwm_trip_i || ocp_trip_i);
  assign max_cut    = gate_q && (on_x4 >= per_x3);
  assign sample_hit = gate_q && (on_q == CNT_W'(SAMPLE_CYC));
  assign low_last   = sample_hit && cs_low_i && (low_q == LOW_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      fault_q <= 1'b0;
      on_q    <= '0;
      low_q   <= '0;
    end else if (restart_i) begin
      gate_q  <= 1'b0;
      fault_q <= 1'b0;
      on_q    <= '0;
      low_q   <= '0;
    end else if (gate_q) begin
      on_q <= on_q + 1'b1;
      if (sample_hit) low_q <= (cs_low_i && !low_last) ? low_q + 1'b1 : '0;
      if (low_last) fault_q <= 1'b1;
      if (trip_cut || max_cut || low_last) gate_q <= 1'b0;
    end else if (period_start_i && !fault_q) begin
      gate_q <= 1'b1;
      on_q   <= CNT_W'(1);
    end
  end

  assign gate_o     = gate_q;
  assign fault_o    = fault_q;
  assign slope_en_o = gate_q && (on_x5 > per_x2);
endmodule

// File: rtl/pcm_cycle_ctrl.sv
module pcm_cycle_ctrl #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned DEF_PERIOD  = 1250,
  parameter int unsigned LEB_CYC     = 40,
  parameter int unsigned SAMPLE_CYC  = 50,
  parameter int unsigned LOW_LIMIT   = 3,
  parameter int unsigned SS_STEPS    = 4,
  parameter int unsigned SS_STEP_CYC = 375000,
  parameter int unsigned REF_W       = 8,
  parameter int unsigned REF_START   = 30,
  parameter int unsigned REF_END     = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             pwm_trip_i,
  input  logic             ocp_trip_i,
  input  logic             cs_low_i,
  input  logic             restart_i,
  output logic             gate_o,
  output logic             slope_en_o,
  output logic [REF_W-1:0] ref_code_o,
  output logic             fault_o
);
  logic [CNT_W-1:0] period_w;

  pcm_period_meas #(
    .CNT_W      (CNT_W),
    .DEF_PERIOD (DEF_PERIOD)
  ) i_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (period_start_i),
    .period_o (period_w)
  );

  pcm_soft_start #(
    .SS_STEPS    (SS_STEPS),
    .SS_STEP_CYC (SS_STEP_CYC),
    .REF_W       (REF_W),
    .REF_START   (REF_START),
    .REF_END     (REF_END)
  ) i_ss (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .ref_o     (ref_code_o)
  );

  pcm_gate_ctrl #(
    .CNT_W      (CNT_W),
    .LEB_CYC    (LEB_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .LOW_LIMIT  (LOW_LIMIT)
  ) i_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .restart_i      (restart_i),
    .period_start_i (period_start_i),
    .pwm_trip_i     (pwm_trip_i),
    .ocp_trip_i     (ocp_trip_i),
    .cs_low_i       (cs_low_i),
    .period_i       (period_w),
    .gate_o         (gate_o),
    .slope_en_o     (slope_en_o),
    .fault_o        (fault_o)
  );
endmodule

// File: rtl/pcm_cycle_ctrl_chk.sv
module pcm_cycle_ctrl_chk #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned LEB_CYC   = 40,
  parameter int unsigned REF_W     = 8,
  parameter int unsigned REF_START = 30,
  parameter int unsigned REF_END   = 80
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             period_start_i,
  input logic             cs_low_i,
  input logic             restart_i,
  input logic             gate_o,
  input logic             slope_en_o,
  input logic             fault_o,
  input logic [REF_W-1:0] ref_code_o,
  input logic [CNT_W-1:0] period_i
);
  localparam int unsigned MUL_W = CNT_W + 4;

  logic [CNT_W:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= '0;
    else if (gate_o) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  AST_GATE_RISE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(period_start_i) && !$past(fault_o)); // R1

  AST_MIN_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) && !$past(restart_i) |-> hi_cnt >= (CNT_W+1)'(LEB_CYC + 1)); // R4

  AST_MAX_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (MUL_W'(hi_cnt) << 2) < (MUL_W'(period_i) * MUL_W'(3))); // R5

  AST_SLOPE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slope_en_o |-> gate_o); // R6

  AST_REF_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_code_o >= REF_W'(REF_START) && ref_code_o <= REF_W'(REF_END)); // R7

  AST_REF_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(restart_i) |-> ref_code_o >= $past(ref_code_o)); // R7

  AST_FAULT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(cs_low_i) && $past(gate_o)); // R8

  AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !gate_o); // R10

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !restart_i |=> fault_o); // R10

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !fault_o && !gate_o && ref_code_o == REF_W'(REF_START)); // R11
endmodule

bind pcm_cycle_ctrl pcm_cycle_ctrl_chk #(
  .CNT_W     (CNT_W),
  .LEB_CYC   (LEB_CYC),
  .REF_W     (REF_W),
  .REF_START (REF_START),
  .REF_END   (REF_END)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .period_start_i (period_start_i),
  .cs_low_i       (cs_low_i),
  .restart_i      (restart_i),
  .gate_o         (gate_o),
  .slope_en_o     (slope_en_o),
  .fault_o        (fault_o),
  .ref_code_o     (ref_code_o),
  .period_i       (period_w)
);

// File: tb/test_pcm_cycle_ctrl.sv
module test_pcm_cycle_ctrl;
  localparam int LEB  = 10;
  localparam int SAMP = 12;
  localparam int STEP = 2000;
  localparam int MAXW = 75;

  typedef struct packed {
    int trip_at;
    bit ocp;
    bit low;
    int exp_w;
    int exp_sf;
  } vec_t;

  localparam vec_t VECS [17] = '{
    '{30, 1'b0, 1'b0, 30, 0},
    '{ 5, 1'b0, 1'b0, 11, 0},
    '{ 1, 1'b1, 1'b0, 11, 0},
    '{50, 1'b1, 1'b0, 50, 41},
    '{ 0, 1'b0, 1'b0, 75, 41},
    '{90, 1'b0, 1'b0, 75, 41},
    '{41, 1'b0, 1'b0, 41, 41},
    '{40, 1'b0, 1'b0, 40, 0},
    '{11, 1'b0, 1'b0, 11, 0},
    '{12, 1'b1, 1'b0, 12, 0},
    '{20, 1'b0, 1'b1, 20, 0},
    '{ 5, 1'b0, 1'b1, 11, 0},
    '{20, 1'b1, 1'b1, 20, 0},
    '{20, 1'b0, 1'b0, 20, 0},
    '{20, 1'b0, 1'b1, 20, 0},
    '{20, 1'b0, 1'b1, 20, 0},
    '{25, 1'b0, 1'b0, 25, 0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       period_start_i = 1'b0;
  logic       pwm_trip_i = 1'b0;
  logic       ocp_trip_i = 1'b0;
  logic       cs_low_i = 1'b0;
  logic       restart_i = 1'b0;
  logic       gate_o, slope_en_o, fault_o;
  logic [7:0] ref_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  pcm_cycle_ctrl #(
    .CNT_W       (10),
    .DEF_PERIOD  (100),
    .LEB_CYC     (LEB),
    .SAMPLE_CYC  (SAMP),
    .LOW_LIMIT   (3),
    .SS_STEPS    (4),
    .SS_STEP_CYC (STEP),
    .REF_W       (8),
    .REF_START   (30),
    .REF_END     (80)
  ) i_pcm_cycle_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .pwm_trip_i     (pwm_trip_i),
    .ocp_trip_i     (ocp_trip_i),
    .cs_low_i       (cs_low_i),
    .restart_i      (restart_i),
    .gate_o         (gate_o),
    .slope_en_o     (slope_en_o),
    .ref_code_o     (ref_code_o),
    .fault_o        (fault_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One switching period of per cycles; the trip is raised from on-time cycle trip_at onward.
  task automatic run_pulse(input int trip_at, input bit use_ocp, input bit low,
                           input int per, output int w, output int sfirst);
    w = 0;
    sfirst = 0;
    cs_low_i = low;
    period_start_i = 1'b1;
    @(negedge clk_i);
    period_start_i = 1'b0;
    for (int i = 0; i < per - 1; i++) begin
      if (gate_o) begin
        w++;
        if (slope_en_o && sfirst == 0) sfirst = w;
      end
      if (trip_at != 0 && w >= trip_at && gate_o) begin
        pwm_trip_i = !use_ocp;
        ocp_trip_i = use_ocp;
      end else begin
        pwm_trip_i = 1'b0;
        ocp_trip_i = 1'b0;
      end
      @(negedge clk_i);
    end
    pwm_trip_i = 1'b0;
    ocp_trip_i = 1'b0;
    cs_low_i   = 1'b0;
  endtask

  initial begin
    int w, sf;
    string lbl;
    repeat (5) @(negedge clk_i);
    // R12: reset state
    chk(gate_o == 1'b0, "R12", "gate in reset", gate_o, 0);
    chk(fault_o == 1'b0, "R12", "fault in reset", fault_o, 0);
    chk(slope_en_o == 1'b0, "R12", "slope in reset", slope_en_o, 0);
    chk(ref_code_o == 8'd30, "R12", "ref in reset", ref_code_o, 30);
    rst_ni = 1'b1;

    // R7: soft-start staircase, sampled mid-step
    repeat (STEP / 2) @(negedge clk_i);
    chk(ref_code_o == 8'd30, "R7", "ref step0", ref_code_o, 30);
    repeat (STEP) @(negedge clk_i);
    chk(ref_code_o == 8'd46, "R7", "ref step1", ref_code_o, 46);
    repeat (STEP) @(negedge clk_i);
    chk(ref_code_o == 8'd63, "R7", "ref step2", ref_code_o, 63);
    repeat (STEP) @(negedge clk_i);
    chk(ref_code_o == 8'd80, "R7", "ref step3", ref_code_o, 80);
    repeat (2 * STEP) @(negedge clk_i);
    chk(ref_code_o == 8'd80, "R7", "ref hold", ref_code_o, 80);

    // Vector table at P=100
    foreach (VECS[n]) begin
      run_pulse(VECS[n].trip_at, VECS[n].ocp, VECS[n].low, 100, w, sf);
      if (VECS[n].trip_at == 0 || VECS[n].trip_at > MAXW) lbl = "R5";
      else if (VECS[n].trip_at <= LEB) lbl = "R4";
      else if (VECS[n].ocp) lbl = "R3";
      else lbl = "R2";
      chk(w == VECS[n].exp_w, lbl, $sformatf("vec%0d width", n), w, VECS[n].exp_w);
      chk(sf == VECS[n].exp_sf, "R6", $sformatf("vec%0d slope first", n), sf, VECS[n].exp_sf);
      chk(fault_o == 1'b0, "R9", $sformatf("vec%0d no fault", n), fault_o, 0);
    end

    // R1: gate rises on the edge sampling the start pulse
    chk(gate_o == 1'b0, "R1", "gate before start", gate_o, 0);
    period_start_i = 1'b1;
    @(negedge clk_i);
    period_start_i = 1'b0;
    chk(gate_o == 1'b1, "R1", "gate after start", gate_o, 1);
    pwm_trip_i = 1'b1;
    repeat (98) @(negedge clk_i);
    pwm_trip_i = 1'b0;
    chk(gate_o == 1'b0, "R4", "gate ended under held trip", gate_o, 0);

    // R8: three consecutive low samples
    run_pulse(20, 1'b0, 1'b1, 100, w, sf);
    chk(w == 20, "R8", "low pulse 1 width", w, 20);
    run_pulse(20, 1'b0, 1'b1, 100, w, sf);
    chk(w == 20, "R8", "low pulse 2 width", w, 20);
    chk(fault_o == 1'b0, "R8", "no fault after two lows", fault_o, 0);
    run_pulse(20, 1'b0, 1'b1, 100, w, sf);
    chk(w == SAMP, "R8", "low pulse 3 width", w, SAMP);
    chk(fault_o == 1'b1, "R8", "fault after three lows", fault_o, 1);

    // R10: start ignored while faulted
    run_pulse(0, 1'b0, 1'b0, 100, w, sf);
    chk(w == 0, "R10", "width while faulted", w, 0);
    chk(fault_o == 1'b1, "R10", "fault held", fault_o, 1);

    // R11: restart
    restart_i = 1'b1;
    @(negedge clk_i);
    restart_i = 1'b0;
    chk(fault_o == 1'b0, "R11", "fault cleared", fault_o, 0);
    chk(ref_code_o == 8'd30, "R11", "soft-start restarted", ref_code_o, 30);
    run_pulse(20, 1'b0, 1'b0, 100, w, sf);
    chk(w == 20, "R11", "pulse after restart", w, 20);

    // R5/R6: measured period follows a shorter spacing
    run_pulse(20, 1'b0, 1'b0, 60, w, sf);
    chk(w == 20, "R2", "width at P=60 transition", w, 20);
    run_pulse(0, 1'b0, 1'b0, 60, w, sf);
    chk(w == 45, "R5", "max width at P=60", w, 45);
    chk(sf == 25, "R6", "slope first at P=60", sf, 25);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule